// File: doc/BRIEF.md
# Bidirectional GPIO Port with Read Inversion and Change Interrupt

This block is the register core of an 8-bit general-purpose I/O port. It holds three writable registers: a direction register, a drive-level register and a read-inversion register. From these it produces a per-pin output enable and output level. It synchronizes the incoming pin levels and returns them, optionally inverted bit by bit, when software reads the pin register. The bus protocol that carries the register accesses lies outside the block, and so do the pad cells that turn the enable and level outputs into real pin drivers.

A change detector keeps a snapshot of the pin levels as they stood at the last pin-register read. It pulls an active-low, open-drain style interrupt whenever a pin configured as an input differs from that snapshot. The interrupt releases when the pin returns to its captured level, or when software reads the pin register again, which also takes a new snapshot. When a pin is switched from output to input while its level differs from the snapshot, the interrupt is raised on purpose.

Top module: `gpio_port_ctl`

## Requirements
- R1: After a synchronous reset, all pins are inputs (`pin_oe` = 8'h00), the drive register reads 8'hFF (`pin_out` = 8'hFF), the inversion register reads 8'h00, `rd_data` is 8'h00, and the interrupt is inactive (`irq_n` = 1, `irq_pull` = 0), even when the pins are not all low during reset.
- R2: Register index 3 is the direction register. A 1 bit makes the pin an input (`pin_oe` bit = 0). A 0 bit makes it an output (`pin_oe` bit = 1). A write is visible on `pin_oe` in the cycle after the write strobe, and the register reads back unchanged.
- R3: Register index 1 is the drive register. Its value appears on `pin_out` in the cycle after a write. It has no effect on pins configured as inputs, because their `pin_oe` bits stay 0.
- R4: A read of index 1 returns the stored drive value, not the pin levels.
- R5: A read of index 0 returns the synchronized pin levels XOR the inversion register, whatever the direction of each pin. Pins pass through two flops. `rd_data` is loaded at the clock edge that samples `rd_en`.
- R6: Register index 2 is the inversion register. It reads back as written: a 1 bit inverts that pin's read value and a 0 bit keeps it.
- R7: When an input pin differs from the snapshot, `irq_n` goes low (and `irq_pull` high) three clock edges after the pin changes. A difference on a pin configured as an output raises no interrupt.
- R8: The interrupt is released, after the same latency, when the pin returns to its snapshot level.
- R9: A read of index 0 loads the snapshot with the synchronized pins and releases the interrupt at the same edge that loads `rd_data`.
- R10: Switching a pin from output to input while its level differs from the snapshot raises the interrupt at the edge that performs the direction write.
- R11: Writes to index 0 change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 2 | Register index for the write |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_idx | input | 2 | Register index for the read |
| pin_in | input | 8 | Raw pin levels |
| pin_oe | output | 8 | Per-pin output enable, 1 = drive |
| pin_out | output | 8 | Per-pin output level |
| rd_data | output | 8 | Registered read data |
| irq_n | output | 1 | Interrupt level, active low |
| irq_pull | output | 1 | Open-drain pull enable, 1 = pull the line low |

## Verification
Writes and reads take effect at the edge that samples the strobe, so the bench sets each strobe at a falling edge and samples the outputs at the next falling edge. A pin change needs three edges to reach the interrupt: two synchronizer stages and the interrupt flop. The bench checks the interrupt both after two edges, when it must be unchanged, and after three, when it must have moved. Before each pin-register read, the bench lets new pin levels settle for three cycles, so the returned value is fully determined.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int IDX_W = 2;
  typedef enum logic [IDX_W-1:0] {
    SEL_PINS   = 2'd0,
    SEL_DRIVE  = 2'd1,
    SEL_INVERT = 2'd2,
    SEL_DIR    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) stage_q[0] <= d;

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
    end
  endgenerate

  assign q = stage_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk2
      // R5: the synchronized value is the pin level two edges earlier
      a_r5_sync_delay: assert property (@(posedge clk) disable iff (rst)
        !$past(rst, 2) |-> q == $past(d, 2));
    end
  endgenerate
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     dir_q,
  output logic [W-1:0]     dir_nxt,
  output logic [W-1:0]     drv_q,
  output logic [W-1:0]     inv_q
);
  localparam logic [W-1:0] ALL_ONES  = {W{1'b1}};
  localparam logic [W-1:0] ALL_ZEROS = '0;

  logic [W-1:0] drv_nxt, inv_nxt;

  always_comb begin
    dir_nxt = dir_q;
    drv_nxt = drv_q;
    inv_nxt = inv_q;
    if (wr_en) begin
      unique case (reg_sel_e'(wr_idx))
        SEL_DIR:    dir_nxt = wr_data;
        SEL_DRIVE:  drv_nxt = wr_data;
        SEL_INVERT: inv_nxt = wr_data;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= ALL_ONES;
      drv_q <= ALL_ONES;
      inv_q <= ALL_ZEROS;
    end else begin
      dir_q <= dir_nxt;
      drv_q <= drv_nxt;
      inv_q <= inv_nxt;
    end
  end

  // R1: reset values
  a_r1_reset_vals: assert property (@(posedge clk)
    rst |=> (dir_q == ALL_ONES && drv_q == ALL_ONES && inv_q == ALL_ZEROS));
  // R11: a write to the pin register leaves every register untouched
  a_r11_pins_ro: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == SEL_PINS) |=> ($stable(dir_q) && $stable(drv_q) && $stable(inv_q)));
endmodule

// File: rtl/gpio_change_det.sv
module gpio_change_det #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] dir_nxt,
  input  logic         pins_read,
  output logic         irq_q
);
  logic [W-1:0] snap_q, snap_nxt, diff;

  assign snap_nxt = (rst || pins_read) ? pin_s : snap_q;
  assign diff     = (pin_s ^ snap_nxt) & dir_nxt;

  always_ff @(posedge clk) begin
    snap_q <= snap_nxt;
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |diff;
  end

  // R9: a pin-register read releases the interrupt at that edge
  a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
    pins_read |=> !irq_q);
  // R7: an active interrupt always has an input pin that differed from the snapshot
  a_r7_input_cause: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> |((snap_q ^ $past(pin_s)) & dir_q));
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [W-1:0]     pin_s,
  input  logic [W-1:0]     dir_q,
  input  logic [W-1:0]     drv_q,
  input  logic [W-1:0]     inv_q,
  output logic [W-1:0]     rd_data
);
  logic [W-1:0] sel;

  always_comb begin
    unique case (reg_sel_e'(rd_idx))
      SEL_PINS:   sel = pin_s ^ inv_q;
      SEL_DRIVE:  sel = drv_q;
      SEL_INVERT: sel = inv_q;
      default:    sel = dir_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= sel;
  end

  // R4: a drive-register read returns the stored value
  a_r4_drive_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_idx == SEL_DRIVE) |=> rd_data == $past(drv_q));
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
  import gpio_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [W-1:0]     pin_in,
  output logic [W-1:0]     pin_oe,
  output logic [W-1:0]     pin_out,
  output logic [W-1:0]     rd_data,
  output logic             irq_n,
  output logic             irq_pull
);
  logic [W-1:0] pin_s, dir_q, dir_nxt, drv_q, inv_q;
  logic         irq_q, pins_read;

  assign pins_read = rd_en && (rd_idx == SEL_PINS);

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s));

  gpio_regfile #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .dir_q(dir_q), .dir_nxt(dir_nxt), .drv_q(drv_q), .inv_q(inv_q));

  gpio_change_det #(.W(W)) u_chg (
    .clk(clk), .rst(rst), .pin_s(pin_s), .dir_q(dir_q), .dir_nxt(dir_nxt),
    .pins_read(pins_read), .irq_q(irq_q));

  gpio_read_mux #(.W(W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_idx(rd_idx), .pin_s(pin_s),
    .dir_q(dir_q), .drv_q(drv_q), .inv_q(inv_q), .rd_data(rd_data));

  assign pin_oe   = ~dir_q;
  assign pin_out  = drv_q;
  assign irq_n    = ~irq_q;
  assign irq_pull = irq_q;

  // R7: open-drain enable and active-low level always agree
  a_r7_pull_matches: assert property (@(posedge clk) irq_pull == !irq_n);
endmodule

// File: tb/gpio_port_ctl_tb.sv
module gpio_port_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // {pins, inversion, direction, expected pin-register read}
  localparam logic [31:0] VEC [NV] = '{
    {8'h00, 8'h00, 8'hFF, 8'h00},
    {8'hA5, 8'h00, 8'hFF, 8'hA5},
    {8'hA5, 8'hFF, 8'hFF, 8'h5A},
    {8'h3C, 8'h0F, 8'h00, 8'h33},
    {8'hFF, 8'h81, 8'hF0, 8'h7E},
    {8'h96, 8'h69, 8'h0F, 8'hFF}
  };

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [1:0] wr_idx = 0, rd_idx = 0;
  logic [7:0] wr_data = 0, pin_in = 8'h5A;
  logic [7:0] pin_oe, pin_out, rd_data;
  logic irq_n, irq_pull;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_ctl dut_i (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_en(rd_en), .rd_idx(rd_idx), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .rd_data(rd_data), .irq_n(irq_n),
    .irq_pull(irq_pull));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_idx = idx; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] idx);
    @(negedge clk); rd_en = 1; rd_idx = idx;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_n(5);
    rst = 0;
    @(negedge clk);
    // R1: reset state, pins 5A during reset captured, no interrupt
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'hFF);
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    chk("R1 irq_pull", {7'd0, irq_pull}, 8'h00);
    rd(2); chk("R1 inversion reset", rd_data, 8'h00);
    rd(3); chk("R1 direction reset", rd_data, 8'hFF);

    // table: R5 pin reads with inversion under several directions
    for (int v = 0; v < NV; v++) begin
      pin_in = VEC[v][31:24];
      wr(2, VEC[v][23:16]);
      wr(3, VEC[v][15:8]);
      wait_n(3);
      rd(0);
      chk("R5 pin read", rd_data, VEC[v][7:0]);
      chk("R9 irq after read", {7'd0, irq_n}, 8'h01);
      chk("R2 pin_oe", pin_oe, ~VEC[v][15:8]);
      rd(2); chk("R6 inversion readback", rd_data, VEC[v][23:16]);
    end

    // R3 / R4: drive register
    wr(3, 8'h0F);
    pin_in = 8'h00;
    wr(1, 8'hA5);
    chk("R3 pin_out", pin_out, 8'hA5);
    chk("R3 input pins not driven", pin_oe & 8'h0F, 8'h00);
    rd(1); chk("R4 drive read not pins", rd_data, 8'hA5);

    // R11: write to pin register changes nothing
    wr(0, 8'h33);
    chk("R11 pin_out", pin_out, 8'hA5);
    chk("R11 pin_oe", pin_oe, 8'hF0);
    rd(2); chk("R11 inversion", rd_data, 8'h69);
    rd(3); chk("R11 direction", rd_data, 8'h0F);

    // R7 / R8 / R9: change interrupt, all inputs
    wr(2, 8'h00);
    wr(3, 8'hFF);
    pin_in = 8'h00; wait_n(3); rd(0);
    chk("R9 baseline irq", {7'd0, irq_n}, 8'h01);
    pin_in = 8'h08;
    wait_n(2); chk("R7 latency two edges", {7'd0, irq_n}, 8'h01);
    wait_n(1); chk("R7 irq asserted", {7'd0, irq_n}, 8'h00);
    chk("R7 pull", {7'd0, irq_pull}, 8'h01);
    pin_in = 8'h00;
    wait_n(3); chk("R8 release on return", {7'd0, irq_n}, 8'h01);
    pin_in = 8'h08;
    wait_n(3); chk("R7 irq again", {7'd0, irq_n}, 8'h00);
    rd(0);
    chk("R9 read clears", {7'd0, irq_n}, 8'h01);
    chk("R9 read value", rd_data, 8'h08);

    // R7: output pin change ignored, then R10 turning it into input
    wr(3, 8'hF7);
    pin_in = 8'h00;
    wait_n(4); chk("R7 output pin ignored", {7'd0, irq_n}, 8'h01);
    wr(3, 8'hFF);
    chk("R10 false irq on direction switch", {7'd0, irq_n}, 8'h00);
    rd(0);
    chk("R10 cleared by read", {7'd0, irq_n}, 8'h01);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule